// File: doc/BRIEF.md
# Multi-zone entry intrusion alarm controller

This block supervises three entry points, such as doors or windows, each fitted with a contact. Each contact reads high while its entry is shut and low once the entry opens. Every contact level is first brought into the clock domain by a two-stage synchroniser. It then has to stay at a new level for a programmable number of consecutive clocks before the controller accepts it. This filters out contact bounce and short glitches.

All I/O sits in one 7-bit general-purpose vector. Bits 0 to 2 are the zone contacts. Bits 3 to 5 are the zone indicators, and bit 6 drives the buzzer. An open zone lights its own indicator and sounds the shared buzzer. The indicator stays lit after that contact closes again. Indicators and buzzer clear together, and only in a cycle where every zone is accepted as closed. On the output vector, bits 0 to 2 read back the accepted (debounced) zone levels.

The block has no streaming data path: every pin is a plain level, so no valid/ready handshake or back-pressure applies.

Top module: `zone_alarm_ctrl`

## Requirements
- R1: After synchronous reset, output bits 3 to 6 (indicators and buzzer) are 0 and read-back bits 0 to 2 are 1 (all zones closed).
- R2: When the debounced level of zone i (input bit i, i = 0..2) is low, output bit 3+i and buzzer bit 6 are set to 1.
- R3: Any combination of open zones lights exactly the indicators of the open zones, with the single buzzer bit 6 on whenever at least one zone is open. All 8 combinations of input bits 0 to 2 are covered.
- R4: A set indicator stays set after its own zone closes again, as long as at least one other zone is still open.
- R5: Indicators and buzzer clear together, and only in a cycle where all three debounced zone levels are high.
- R6: A synchronised input must hold a new level for DEB_CYCLES consecutive clocks before the debounced level changes. A level held for fewer clocks has no effect.
- R7: After an input change held long enough, read-back bits 0 to 2 change exactly 2+DEB_CYCLES clocks later. Indicators and buzzer change exactly one clock after that.
- R8: Input bits 3 to 6 are ignored.
- R9: Output bits 0 to 2 return the debounced zone levels, in zone order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock (timing target 50 ns period) |
| rst | input | 1 | Synchronous reset, active high |
| gpio_in | input | 7 | I/O vector in; bits 0..2 are zone contacts (1 = closed) |
| gpio_out | output | 7 | I/O vector out; bits 0..2 debounced zones, 3..5 indicators, 6 buzzer |

## Verification
The bench targets the hold case, where a zone closes while another is still open. A design that clears per zone would drop that indicator early. Bounce pulses one clock shorter than the debounce window are checked against a pulse of exactly the window. An off-by-one counter would either latch the short pulse or miss the full one. Exact-cycle sampling around an input edge catches a missing synchroniser stage or an unregistered output path. Toggling the unused upper input bits exposes any decode that leaks them into the zone logic.

// File: rtl/zone_alarm_pkg.sv
package zone_alarm_pkg;
  localparam int NUM_ZONES = 3;
  localparam int IND_BASE  = NUM_ZONES;
  localparam int BUZZ_BIT  = 2 * NUM_ZONES;
  localparam int IO_W      = BUZZ_BIT + 1;
endpackage

// File: rtl/zone_sync.sv
module zone_sync (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic sync_out
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= 1'b1;
      sync_out <= 1'b1;
    end else begin
      stage1   <= raw_in;
      sync_out <= stage1;
    end
  end

  // R7: second stage follows the first with one clock of delay
  a_r7_two_stage: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sync_out == $past(stage1));
endmodule

// File: rtl/zone_debounce.sv
module zone_debounce #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic level_out
);
  localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_out <= 1'b1;
      run_cnt   <= '0;
    end else if (level_in == level_out) begin
      run_cnt <= '0;
    end else if (run_cnt == CNT_LAST) begin
      level_out <= level_in;
      run_cnt   <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R6: agreeing input never moves the accepted level
  a_r6_agree_stable: assert property (@(posedge clk) disable iff (rst)
    (level_in == level_out) |=> $stable(level_out));
  // R6: a differing input before the window completes does not flip it
  a_r6_no_early_flip: assert property (@(posedge clk) disable iff (rst)
    (level_in != level_out && run_cnt != CNT_LAST) |=> $stable(level_out));
endmodule

// File: rtl/zone_latch.sv
module zone_latch #(
  parameter int ZONES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ZONES-1:0] zone_ok,
  output logic [ZONES-1:0] ind,
  output logic             buzz
);
  logic all_closed;
  assign all_closed = &zone_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ind  <= '0;
      buzz <= 1'b0;
    end else if (!all_closed) begin
      ind  <= ind | ~zone_ok;
      buzz <= 1'b1;
    end else begin
      ind  <= '0;
      buzz <= 1'b0;
    end
  end

  for (genvar i = 0; i < ZONES; i++) begin : g_chk
    // R2: an open zone sets its own indicator and the buzzer
    a_r2_set_on_open: assert property (@(posedge clk) disable iff (rst)
      !zone_ok[i] |=> ind[i] && buzz);
    // R4: a lit indicator holds while any zone is open
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (ind[i] && !all_closed) |=> ind[i]);
  end

  // R5: all closed clears every indicator and the buzzer together
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    all_closed |=> (ind == '0) && !buzz);
  // R3: buzzer is on exactly when some indicator is lit
  a_r3_buzz_any: assert property (@(posedge clk) disable iff (rst)
    buzz == (ind != '0));
endmodule

// File: rtl/zone_alarm_ctrl.sv
module zone_alarm_ctrl
  import zone_alarm_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IO_W-1:0] gpio_in,
  output logic [IO_W-1:0] gpio_out
);
  logic [NUM_ZONES-1:0] synced;
  logic [NUM_ZONES-1:0] accepted;
  logic [NUM_ZONES-1:0] ind;
  logic                 buzz;
  logic                 unused_hi;

  assign unused_hi = ^gpio_in[IO_W-1:NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    zone_sync u_sync (
      .clk      (clk),
      .rst      (rst),
      .raw_in   (gpio_in[z]),
      .sync_out (synced[z])
    );
    zone_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk       (clk),
      .rst       (rst),
      .level_in  (synced[z]),
      .level_out (accepted[z])
    );
  end

  zone_latch #(.ZONES(NUM_ZONES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .zone_ok (accepted),
    .ind     (ind),
    .buzz    (buzz)
  );

  assign gpio_out[NUM_ZONES-1:0]        = accepted;
  assign gpio_out[BUZZ_BIT-1:IND_BASE]  = ind;
  assign gpio_out[BUZZ_BIT]             = buzz;

  // R1: indicators and buzzer are 0 in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> gpio_out[BUZZ_BIT:IND_BASE] == '0);
endmodule

// File: tb/zone_alarm_ctrl_tb.sv
module zone_alarm_ctrl_tb;
  localparam int DEB = 4;
  localparam int SETTLE = DEB + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] gpio_in = 7'h07;
  logic [6:0] gpio_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  zone_alarm_ctrl #(.DEB_CYCLES(DEB)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .gpio_in  (gpio_in),
    .gpio_out (gpio_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [6:0] exp, input string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  function automatic logic [6:0] model(input logic [2:0] zones, input logic [2:0] lit);
    return {(lit != 3'b000), lit, zones};
  endfunction

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_exp.size() > 0) begin
        logic [6:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (gpio_out !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, gpio_out, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_out(7'b0000111, "R1 reset state");

    // single zone open then closed
    gpio_in = 7'b0000110;
    step(SETTLE);
    expect_out(model(3'b110, 3'b001), "R2 zone0 open");
    gpio_in = 7'b0000111;
    step(SETTLE);
    expect_out(7'b0000111, "R5 zone0 closed clears");

    // every combination
    for (int v = 0; v < 8; v++) begin
      gpio_in = {4'b0000, 3'(v)};
      step(SETTLE);
      expect_out(model(3'(v), ~3'(v)), "R3 combination");
      gpio_in = 7'b0000111;
      step(SETTLE);
      expect_out(7'b0000111, "R5 clear after combination");
    end

    // hold while another zone is open
    gpio_in = 7'b0000110;
    step(SETTLE);
    gpio_in = 7'b0000100;
    step(SETTLE);
    expect_out(model(3'b100, 3'b011), "R3 two zones open");
    gpio_in = 7'b0000101;
    step(SETTLE);
    expect_out(model(3'b101, 3'b011), "R4 zone0 closed but latched");
    gpio_in = 7'b0000111;
    step(SETTLE);
    expect_out(7'b0000111, "R5 all closed clears together");

    // exact latency
    gpio_in = 7'b0000011;
    step(DEB + 1);
    expect_out(7'b0000111, "R7 readback not yet changed");
    step(1);
    expect_out(7'b0000011, "R7 R9 readback changes at 2+DEB");
    step(1);
    expect_out(model(3'b011, 3'b100), "R7 indicator one clock later");
    gpio_in = 7'b0000111;
    step(DEB + 2);
    expect_out(model(3'b111, 3'b100), "R7 clear waits one clock");
    step(1);
    expect_out(7'b0000111, "R5 R7 cleared");

    // debounce: short pulse ignored, full pulse accepted
    gpio_in = 7'b0000110;
    step(SETTLE);
    gpio_in = 7'b0000010;
    step(DEB - 1);
    gpio_in = 7'b0000110;
    step(1);
    gpio_in = 7'b0000010;
    step(DEB - 1);
    gpio_in = 7'b0000110;
    step(SETTLE);
    expect_out(model(3'b110, 3'b001), "R6 short pulses ignored");
    gpio_in = 7'b0000010;
    step(DEB);
    gpio_in = 7'b0000110;
    step(SETTLE);
    expect_out(model(3'b110, 3'b101), "R6 full-window pulse latched");
    gpio_in = 7'b0000111;
    step(SETTLE);
    expect_out(7'b0000111, "R5 cleared after debounce test");

    // upper input bits ignored
    gpio_in = 7'b1111111;
    step(SETTLE);
    expect_out(7'b0000111, "R8 upper bits high ignored");
    gpio_in = 7'b1010101;
    step(SETTLE);
    expect_out(model(3'b101, 3'b010), "R8 upper bits with zone1 open");
    gpio_in = 7'b0101111;
    step(SETTLE);
    expect_out(7'b0000111, "R8 R5 upper bits toggled, cleared");

    step(2);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule